// File: doc/BRIEF.md
# Serial Command and Fault Status Register for an Eight-Channel Driver

This block is the serial slave interface of an eight-channel output driver. A host selects the device by pulling the active-low select line low. At that moment the block copies the per-channel fault flags into an 8-bit shift register. While the host clocks the frame, the block shifts the status out of the data output, most significant bit first, and shifts command bits in from the data input. When the select line returns high, the last eight bits received become the new output command.

Bits that have passed through the shift register leave on the data output. This lets several devices share one frame in a daisy chain. It also lets a host check the link: a 16-bit frame returns the status byte first and then the first byte the host sent.

Fault flags are sticky. A flag stays set until a frame start captures it, even if the fault has already cleared. While the logic supply reports undervoltage, the status register is held clear and every output is forced off. The stored command comes back into effect when the supply recovers. The serial lines are sampled by the system clock, and serial edges are detected from those samples.

Top module: `octal_cmd_stat`

## Requirements
- R1: After reset, `cmd_out` is 8'h00 (all channels off), and `sdo_oe` is 0 while `cs_n` is high.
- R2: One clock after `cs_n` falls, the shift register holds the status byte and `sdo` shows status bit 7.
- R3: `sdi` is sampled on each rising `sclk` edge while selected. `sdo` advances to the next bit, MSB first, on each falling `sclk` edge, so it is stable at the next rising edge.
- R4: In a 16-bit frame, output bits 1 to 8 are status bits 7 down to 0, and output bits 9 to 16 are the first eight bits received, in the order they were received.
- R5: One clock after `cs_n` rises, `cmd_out` equals the last eight bits received, with the first of them in bit 7. `cmd_out` does not change at any other time.
- R6: Status bit i is 1 when `fault_in[i]` has been high since the previous frame start, or is high at the current frame start. Captured flags are cleared at a frame start unless their fault is still present.
- R7: While `uv` is high, `cmd_out` is 8'h00 and the status register is held at 0. After `uv` falls, `cmd_out` returns to the stored command.
- R8: While `cs_n` is high, `sdo_oe` is 0, and `sclk` edges change neither `cmd_out` nor the status returned by the next frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| uv | input | 1 | Logic-supply undervoltage flag |
| fault_in | input | 8 | Per-channel fault flags, 1 = fault |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock, mode 0 |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the tri-state `sdo` driver |
| cmd_out | output | 8 | Per-channel output command, 1 = on |

## Verification
Every serial edge takes effect one system clock after the sample that sees it. The shift register and `sdo` are valid one clock after `cs_n` falls, `sdo` moves one clock after a falling `sclk`, and `cmd_out` updates one clock after `cs_n` rises. The bench holds each `sclk` level for at least two clocks and reads `sdo` at the instant `sclk` rises. It also waits two clocks after `cs_n` rises before comparing `cmd_out`. The expected serial bits come from a model of sticky status, and the scoreboard compares them bit by bit at those instants.

// File: rtl/octal_cmd_stat.sv
module octal_cmd_stat #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         uv,
  input  logic [W-1:0] fault_in,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         sdi,
  output logic         sdo,
  output logic         sdo_oe,
  output logic [W-1:0] cmd_out
);

  logic [W-1:0] stat, shreg, cmd;
  logic cs_d, sclk_d, sdo_q;

  wire cs_fall  = cs_d & ~cs_n;
  wire cs_rise  = ~cs_d & cs_n;
  wire sck_rise = ~sclk_d & sclk & ~cs_n & ~cs_d;
  wire sck_fall = sclk_d & ~sclk & ~cs_n & ~cs_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= cs_n;
      sclk_d <= sclk;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        stat <= '0;
    else if (uv)       stat <= '0;
    else if (cs_fall)  stat <= fault_in;
    else               stat <= stat | fault_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        shreg <= '0;
    else if (cs_fall)  shreg <= stat;
    else if (sck_rise) shreg <= {shreg[W-2:0], sdi};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        sdo_q <= 1'b0;
    else if (cs_fall)  sdo_q <= stat[W-1];
    else if (sck_fall) sdo_q <= shreg[W-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       cmd <= '0;
    else if (cs_rise) cmd <= shreg;

  assign sdo     = sdo_q;
  assign sdo_oe  = ~cs_n;
  assign cmd_out = uv ? '0 : cmd;

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_d && !cs_n) |=> (shreg == $past(stat)));

  a_r5_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs_n && !cs_d) |=> $stable(cmd));

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!(cs_d && !cs_n) && !uv) |=> ((stat & $past(stat)) == $past(stat)));

  a_r7_uv_clear: assert property (@(posedge clk) disable iff (!rst_n)
    uv |=> (stat == '0));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && cs_d) |=> $stable(shreg));

endmodule

// File: tb/octal_cmd_stat_test.sv
`timescale 1ns/1ps
module octal_cmd_stat_test;
  logic clk = 0, rst_n = 0, uv = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic [7:0] fault_in = '0;
  logic sdo, sdo_oe;
  logic [7:0] cmd_out;
  int vecs = 0, bad = 0;
  bit exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  octal_cmd_stat uut (.clk, .rst_n, .uv, .fault_in, .cs_n, .sclk, .sdi,
                      .sdo, .sdo_oe, .cmd_out);

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge sclk) if (!cs_n) begin
    vecs++;
    if (exp_q.size() == 0) begin
      bad++;
      $display("FAIL R3: unexpected bit got %b expected none", sdo);
    end else begin
      automatic bit e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      if (sdo !== e) begin
        bad++;
        $display("FAIL %s: sdo got %b expected %b", t, sdo, e);
      end
    end
  end

  task automatic frame(int n, logic [15:0] din, logic [7:0] st, string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(i < 8 ? st[7-i] : din[n-1-(i-8)]);
      tag_q.push_back(i < 8 ? tag : "R4");
    end
    @(negedge clk) cs_n = 0;
    repeat (2) @(negedge clk);
    chk("R8 oe", {7'b0, sdo_oe}, 8'h01);
    for (int i = 0; i < n; i++) begin
      sdi = din[n-1-i];
      @(negedge clk) sclk = 1;
      repeat (2) @(negedge clk);
      sclk = 0;
      repeat (2) @(negedge clk);
    end
    cs_n = 1;
    repeat (2) @(negedge clk);
    chk("R5 cmd", cmd_out, din[7:0]);
    chk("R3 drained", 8'(exp_q.size()), 8'h00);
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cmd reset", cmd_out, 8'h00);
    chk("R1 oe", {7'b0, sdo_oe}, 8'h00);
    rst_n = 1;
    repeat (2) @(negedge clk);
    frame(16, 16'hA55A, 8'h00, "R2");
    fault_in = 8'h81; @(negedge clk); fault_in = 8'h00;
    repeat (2) @(negedge clk);
    frame(8, 16'h00C3, 8'h81, "R6");
    frame(8, 16'h003C, 8'h00, "R6 cleared");
    fault_in = 8'h04;
    repeat (2) @(negedge clk);
    frame(16, 16'h1234, 8'h04, "R6 held");
    frame(16, 16'hFF00, 8'h04, "R6 present");
    fault_in = 8'h00;
    frame(8, 16'h0096, 8'h04, "R6 last");
    for (int i = 0; i < 6; i++) begin
      @(negedge clk) sclk = ~sclk;
      sdi = ~sdi;
    end
    sclk = 0;
    repeat (2) @(negedge clk);
    chk("R8 idle cmd", cmd_out, 8'h96);
    chk("R8 idle oe", {7'b0, sdo_oe}, 8'h00);
    frame(8, 16'h0069, 8'h00, "R8 status");
    fault_in = 8'h10; @(negedge clk); fault_in = 8'h00;
    uv = 1;
    repeat (3) @(negedge clk);
    chk("R7 off", cmd_out, 8'h00);
    uv = 0;
    repeat (2) @(negedge clk);
    chk("R7 restore", cmd_out, 8'h69);
    frame(16, 16'h5AF0, 8'h00, "R7 status");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule